// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a small microcontroller between full-speed operation and two
sleep levels. The CPU core issues a one-cycle strobe when it executes a wait or a
stop instruction. The sequencer then gates the CPU clock, clears the interrupt mask
so that a request can wake the core, and drives the enables of the oscillator, the
PLL and the clock-generator outputs according to the chosen sleep level and a
configuration bit that lets the oscillator run through stop.

Light sleep (wait) leaves the clock generator running and uses the PLL settings that
software already programmed. Deep sleep (stop) always turns off the PLL. When the
keep-oscillator option is clear, it also turns off the oscillator and holds every
clock-generator output low. Then, on wake-up, a stabilization counter must expire
before the CPU clock restarts. A sticky flag records that a break request ended a
sleep, so the break handler can adjust its return address. The core, the analog
oscillator and PLL, and the break comparator are outside the block. They appear
only as enable, ready and request signals.

Top module: `lpm_sequencer`

## Requirements
- R1: `cpu_clk_en` is 1 only when the state is RUN and `osc_ready` is 1. It is 0 in WAIT, STOP and STABILIZE.
- R2: In RUN, a `stop_req` moves the state to STOP on the next edge and a `wait_req` moves it to WAIT. If both arrive together, stop wins. Either entry clears `irq_mask`. State code on `state_o`: RUN=0, WAIT=1, STOP=2, STABILIZE=3.
- R3: WAIT ends on the next edge when `ext_irq` or `int_irq` is 1, or when `brk_irq` and `brk_enable` are both 1. The state returns to RUN and `irq_mask` stays 0.
- R4: When `rst_n` is low at an edge, the block goes to RUN with `irq_mask`=1 and `brk_flag`=0, whatever state it was in.
- R5: In WAIT, `pll_en` follows `sw_pll_on` and `pll_sel` follows `sw_pll_sel`. `osc_en` and `cgm_out_en` are 1.
- R6: In STOP, when `osc_keep_cfg` was 0 at entry, `osc_en`, `pll_en`, `pll_sel` and `cgm_out_en` are all 0.
- R7: In STOP, when `osc_keep_cfg` was 1 at entry, `osc_en` and `cgm_out_en` are 1, and `pll_en` and `pll_sel` are 0.
- R8: STOP ends only on `ext_irq` or `brk_irq`. An `int_irq` alone leaves the state in STOP, and `irq_mask` stays 0.
- R9: A stop exit goes to STABILIZE when the oscillator was stopped. STABILIZE lasts `stab_limit` edges at which `osc_ready` is 1 (a limit of 0 counts as 1) and then returns to RUN. A stop exit with the oscillator kept goes straight to RUN.
- R10: `brk_flag` sets when a break request ends a sleep: `brk_irq` in STOP, or `brk_irq` with `brk_enable` in WAIT. A write (`flag_wr`=1) with `flag_wdata`=0 clears it. A write of 1 has no effect. Setting has priority over clearing.
- R11: `brk_active` equals `brk_enable` in every state except STOP and STABILIZE, where it is 0.
- R12: In RUN with no sleep strobe, `mask_set` sets `irq_mask` and `mask_clr` clears it, with set winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_req | input | 1 | Wait instruction strobe |
| stop_req | input | 1 | Stop instruction strobe |
| mask_set | input | 1 | CPU request to set the interrupt mask |
| mask_clr | input | 1 | CPU request to clear the interrupt mask |
| ext_irq | input | 1 | External interrupt request |
| int_irq | input | 1 | Internal peripheral interrupt request |
| brk_irq | input | 1 | Break interrupt request |
| brk_enable | input | 1 | Break logic enabled by software |
| osc_keep_cfg | input | 1 | Keep oscillator running in stop |
| sw_pll_on | input | 1 | Software PLL power bit |
| sw_pll_sel | input | 1 | Software PLL select bit |
| osc_ready | input | 1 | Oscillator produces clean edges |
| stab_limit | input | CNT_W | Stabilization length in oscillator cycles |
| flag_wr | input | 1 | Software write strobe for the break flag |
| flag_wdata | input | 1 | Data of that write |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL power enable |
| pll_sel | output | 1 | PLL selected as bus clock source |
| cgm_out_en | output | 1 | Clock-generator outputs enabled (0 holds them low) |
| brk_active | output | 1 | Break logic may operate |
| irq_mask | output | 1 | Interrupt mask bit |
| brk_flag | output | 1 | Break ended a sleep |
| state_o | output | 2 | Current power state code |

## Verification
The assertions watch on every cycle that the CPU clock stays gated outside RUN and that a sleep entry clears the mask. They also check that stop without the keep option drives all clock-generator enables low, that an internal request cannot end stop, and that a break exit raises the flag. The exact length of STABILIZE under a programmed limit is shown only by the bench's scenarios. So are the limit-of-zero case, the direct return when the oscillator was kept, the ignored write of 1 to the flag, and reset from deep sleep. A reference model in the bench follows long random mixes of strobes and requests.

// File: rtl/lpm_pkg.sv
// Package: shared state encoding for the low-power mode sequencer.
// Assumes: a two-bit code; software reads the same code on state_o.
package lpm_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_STOP = 2'd2,
        ST_STAB = 2'd3
    } lpm_state_e;
endpackage

// File: rtl/lpm_wake_ctrl.sv
// Module: lpm_wake_ctrl
// Decides, for the current power state, whether the pending requests end the
// sleep and whether a break request is among the causes.
// Assumes: requests are synchronous levels; in stop only external and break
// requests are seen, in wait any request (break only when enabled).
module lpm_wake_ctrl
    import lpm_pkg::*;
(
    input  lpm_state_e state,
    input  logic       ext_irq,
    input  logic       int_irq,
    input  logic       brk_irq,
    input  logic       brk_enable,
    output logic       wake,
    output logic       brk_cause
);
    // Wake and cause decode per state.
    always_comb begin
        wake      = 1'b0;
        brk_cause = 1'b0;
        case (state)
            ST_WAIT: begin
                brk_cause = brk_irq & brk_enable;
                wake      = ext_irq | int_irq | brk_cause;
            end
            ST_STOP: begin
                brk_cause = brk_irq;
                wake      = ext_irq | brk_irq;
            end
            default: begin
                wake      = 1'b0;
                brk_cause = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lpm_stab_timer.sv
// Module: lpm_stab_timer
// Counts oscillator cycles after a deep-sleep exit and reports when the
// programmed stabilization length has been reached.
// Assumes: start is a one-cycle pulse on the stop exit edge; the count only
// advances on edges where the oscillator reports ready; a limit of 0 acts as 1.
module lpm_stab_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic             osc_ready,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [EXT_W-1:0] next_cnt;

    // Count of ready cycles already spent, widened to avoid wrap on compare.
    assign next_cnt = {1'b0, cnt} + EXT_W'(1);

    // Stabilization is over on the ready edge that reaches the limit.
    assign done = active && osc_ready && (next_cnt >= {1'b0, limit});

    // Cycle counter: cleared on start, advanced on ready cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (active && osc_ready && !done) begin
            cnt <= next_cnt[CNT_W-1:0];
        end
    end

    AST_STAB_HOLDS_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !osc_ready && !start) |=> $stable(cnt)) else $error("stab count moved"); // R9
endmodule

// File: rtl/lpm_clk_ctrl.sv
// Module: lpm_clk_ctrl
// Derives the clock-generator and CPU clock enables from the power state,
// the keep-oscillator choice latched at stop entry and the software PLL bits.
// Assumes: software PLL bits are honoured unchanged in RUN and WAIT.
module lpm_clk_ctrl
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lpm_state_e state,
    input  logic       keep_q,
    input  logic       osc_ready,
    input  logic       sw_pll_on,
    input  logic       sw_pll_sel,
    input  logic       brk_enable,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       pll_en,
    output logic       pll_sel,
    output logic       cgm_out_en,
    output logic       brk_active
);
    logic awake_cgm;
    logic osc_off;

    // Clock generator keeps its software setup only in RUN and WAIT.
    assign awake_cgm = (state == ST_RUN) || (state == ST_WAIT);
    // Oscillator is stopped in deep sleep unless kept.
    assign osc_off   = (state == ST_STOP) && !keep_q;

    // Enable decode.
    always_comb begin
        cpu_clk_en = (state == ST_RUN) && osc_ready;
        osc_en     = !osc_off;
        cgm_out_en = !osc_off;
        pll_en     = awake_cgm && sw_pll_on;
        pll_sel    = awake_cgm && sw_pll_sel;
        brk_active = brk_enable && awake_cgm;
    end

    AST_STOP_CLOCKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !keep_q) |-> !(osc_en || pll_en || pll_sel || cgm_out_en)) else $error("clock alive in stop"); // R6
    AST_STOP_OSC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && keep_q) |-> (osc_en && cgm_out_en && !pll_en && !pll_sel)) else $error("keep option ignored"); // R7
endmodule

// File: rtl/lpm_sequencer.sv
// Module: lpm_sequencer (top)
// Power-state machine RUN / WAIT / STOP / STABILIZE with interrupt-mask
// handling by exit cause and a sticky break-exit flag.
// Assumes: wait_req/stop_req are single-cycle strobes from the core; the
// mask set/clear strobes come from the core's mask instructions.
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_req,
    input  logic             stop_req,
    input  logic             mask_set,
    input  logic             mask_clr,
    input  logic             ext_irq,
    input  logic             int_irq,
    input  logic             brk_irq,
    input  logic             brk_enable,
    input  logic             osc_keep_cfg,
    input  logic             sw_pll_on,
    input  logic             sw_pll_sel,
    input  logic             osc_ready,
    input  logic [CNT_W-1:0] stab_limit,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             pll_en,
    output logic             pll_sel,
    output logic             cgm_out_en,
    output logic             brk_active,
    output logic             irq_mask,
    output logic             brk_flag,
    output logic [1:0]       state_o
);
    lpm_state_e state, state_nx;
    logic       keep_q;
    logic       wake, brk_cause;
    logic       stab_start, stab_done;

    lpm_wake_ctrl u_wake (
        .state      (state),
        .ext_irq    (ext_irq),
        .int_irq    (int_irq),
        .brk_irq    (brk_irq),
        .brk_enable (brk_enable),
        .wake       (wake),
        .brk_cause  (brk_cause)
    );

    // Timer starts on the edge that leaves stop toward stabilization.
    assign stab_start = (state == ST_STOP) && wake && !keep_q;

    lpm_stab_timer #(.CNT_W(CNT_W)) u_stab (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (stab_start),
        .active    (state == ST_STAB),
        .osc_ready (osc_ready),
        .limit     (stab_limit),
        .done      (stab_done)
    );

    lpm_clk_ctrl u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .keep_q     (keep_q),
        .osc_ready  (osc_ready),
        .sw_pll_on  (sw_pll_on),
        .sw_pll_sel (sw_pll_sel),
        .brk_enable (brk_enable),
        .cpu_clk_en (cpu_clk_en),
        .osc_en     (osc_en),
        .pll_en     (pll_en),
        .pll_sel    (pll_sel),
        .cgm_out_en (cgm_out_en),
        .brk_active (brk_active)
    );

    // Next-state decode.
    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN:  if (stop_req) state_nx = ST_STOP;
                     else if (wait_req) state_nx = ST_WAIT;
            ST_WAIT: if (wake) state_nx = ST_RUN;
            ST_STOP: if (wake) state_nx = keep_q ? ST_RUN : ST_STAB;
            ST_STAB: if (stab_done) state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Keep-oscillator choice captured when stop is entered.
    always_ff @(posedge clk) begin
        if (!rst_n)                               keep_q <= 1'b0;
        else if (state == ST_RUN && stop_req)     keep_q <= osc_keep_cfg;
    end

    // Interrupt mask: set by reset, cleared on sleep entry, core-controlled in RUN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_mask <= 1'b1;
        end else if (state == ST_RUN) begin
            if (stop_req || wait_req) irq_mask <= 1'b0;
            else if (mask_set)        irq_mask <= 1'b1;
            else if (mask_clr)        irq_mask <= 1'b0;
        end
    end

    // Break-exit flag: set by a break wake, cleared by a software write of zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    brk_flag <= 1'b0;
        else if (wake && brk_cause)    brk_flag <= 1'b1;
        else if (flag_wr && !flag_wdata) brk_flag <= 1'b0;
    end

    assign state_o = state;

    AST_CLK_OFF_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0) |-> !cpu_clk_en) else $error("cpu clock while asleep"); // R1
    AST_ENTRY_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && (stop_req || wait_req)) |=> (!irq_mask && state != ST_RUN)) else $error("sleep entry"); // R2
    AST_WAIT_WAKE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && (ext_irq || int_irq)) |=> (state == ST_RUN && !irq_mask)) else $error("wait wake"); // R3
    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (state == ST_RUN && irq_mask && !brk_flag)) else $error("reset values"); // R4
    AST_INT_NO_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && int_irq && !ext_irq && !brk_irq) |=> (state == ST_STOP)) else $error("int left stop"); // R8
    AST_BRK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && brk_irq) |=> brk_flag) else $error("break flag"); // R10
endmodule

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;
    localparam int CLK_P = 10;
    localparam int CNT_W = 13;

    logic clk = 1'b0;
    logic rst_n, wait_req, stop_req, mask_set, mask_clr, ext_irq, int_irq, brk_irq;
    logic brk_enable, osc_keep_cfg, sw_pll_on, sw_pll_sel, osc_ready, flag_wr, flag_wdata;
    logic [CNT_W-1:0] stab_limit;
    logic cpu_clk_en, osc_en, pll_en, pll_sel, cgm_out_en, brk_active, irq_mask, brk_flag;
    logic [1:0] state_o;

    int n_run = 0;
    int n_fail = 0;

    // Reference model state.
    logic [1:0] m_st;
    logic m_mask, m_flag, m_keep;
    int   m_cnt;

    always #(CLK_P/2) clk = ~clk;

    lpm_sequencer #(.CNT_W(CNT_W)) dut (.*);

    function automatic logic exp_wake(logic [1:0] st);
        if (st == 2'd1) return ext_irq | int_irq | (brk_irq & brk_enable);
        if (st == 2'd2) return ext_irq | brk_irq;
        return 1'b0;
    endfunction

    function automatic logic exp_brk(logic [1:0] st);
        if (st == 2'd1) return brk_irq & brk_enable;
        if (st == 2'd2) return brk_irq;
        return 1'b0;
    endfunction

    // Model update at a clock edge, from the requirements.
    task automatic model_edge();
        logic w, b, setf;
        int lim;
        w = exp_wake(m_st);
        b = exp_brk(m_st);
        setf = w & b;
        lim = (stab_limit == 0) ? 1 : int'(stab_limit);
        if (!rst_n) begin
            m_st = 2'd0; m_mask = 1'b1; m_flag = 1'b0; m_keep = 1'b0; m_cnt = 0;
        end else begin
            case (m_st)
                2'd0: begin
                    if (stop_req) begin m_st = 2'd2; m_keep = osc_keep_cfg; m_mask = 1'b0; end
                    else if (wait_req) begin m_st = 2'd1; m_mask = 1'b0; end
                    else if (mask_set) m_mask = 1'b1;
                    else if (mask_clr) m_mask = 1'b0;
                end
                2'd1: if (w) m_st = 2'd0;
                2'd2: if (w) begin m_st = m_keep ? 2'd0 : 2'd3; m_cnt = 0; end
                default: if (osc_ready) begin
                    if (m_cnt + 1 >= lim) m_st = 2'd0;
                    else m_cnt = m_cnt + 1;
                end
            endcase
            if (setf) m_flag = 1'b1;
            else if (flag_wr && !flag_wdata) m_flag = 1'b0;
        end
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model (called away from the edge).
    task automatic check_all();
        logic awake;
        awake = (m_st == 2'd0) || (m_st == 2'd1);
        chk("R2 R3 R8 R9 state", {6'd0, state_o}, {6'd0, m_st});
        chk("R2 R4 R12 mask", {7'd0, irq_mask}, {7'd0, m_mask});
        chk("R10 flag", {7'd0, brk_flag}, {7'd0, m_flag});
        chk("R1 cpu clock", {7'd0, cpu_clk_en}, {7'd0, (m_st == 2'd0) && osc_ready});
        chk("R5 R6 R7 osc", {6'd0, osc_en, cgm_out_en},
            {6'd0, {2{!((m_st == 2'd2) && !m_keep)}}});
        chk("R5 R6 R7 pll", {6'd0, pll_en, pll_sel},
            {6'd0, awake && sw_pll_on, awake && sw_pll_sel});
        chk("R11 break active", {7'd0, brk_active}, {7'd0, brk_enable && awake});
    endtask

    task automatic idle_inputs();
        rst_n = 1'b1; wait_req = 0; stop_req = 0; mask_set = 0; mask_clr = 0;
        ext_irq = 0; int_irq = 0; brk_irq = 0; flag_wr = 0; flag_wdata = 0;
    endtask

    // One cycle: edge, model update, then check at the falling edge.
    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int stab_len;
        void'($urandom(32'd2024));
        idle_inputs();
        rst_n = 0; brk_enable = 1; osc_keep_cfg = 0; sw_pll_on = 1; sw_pll_sel = 1;
        osc_ready = 1; stab_limit = CNT_W'(5);
        m_st = 0; m_mask = 1; m_flag = 0; m_keep = 0; m_cnt = 0;
        @(negedge clk);
        cycle(); cycle();
        // R4: reset values.
        chk("R4 reset state", {6'd0, state_o}, 8'd0);
        chk("R4 reset mask", {7'd0, irq_mask}, 8'd1);
        idle_inputs();
        cycle();

        // R8, R6: stop without keep; an internal request does not wake.
        stop_req = 1; cycle(); stop_req = 0;
        chk("R6 oscillator off in stop", {7'd0, osc_en}, 8'd0);
        int_irq = 1; cycle(); cycle(); int_irq = 0;
        chk("R8 stays in stop", {6'd0, state_o}, 8'd2);
        // R9: STABILIZE length equals the limit of 5.
        ext_irq = 1; cycle(); ext_irq = 0;
        stab_len = 0;
        for (int i = 0; i < 20 && state_o == 2'd3; i++) begin cycle(); stab_len++; end
        chk("R9 stabilize length", 8'(stab_len), 8'd5);
        chk("R1 clock back on", {7'd0, cpu_clk_en}, 8'd1);

        // R7, R9: keep option, direct return; break sets the flag (R10).
        osc_keep_cfg = 1; stop_req = 1; cycle(); stop_req = 0; osc_keep_cfg = 0;
        chk("R7 oscillator kept", {6'd0, osc_en, pll_en}, 8'b10);
        brk_irq = 1; cycle(); brk_irq = 0;
        chk("R9 keep skips delay", {6'd0, state_o}, 8'd0);
        chk("R10 flag set", {7'd0, brk_flag}, 8'd1);
        flag_wr = 1; flag_wdata = 1; cycle();
        chk("R10 write one ignored", {7'd0, brk_flag}, 8'd1);
        flag_wdata = 0; cycle(); flag_wr = 0;
        chk("R10 write zero clears", {7'd0, brk_flag}, 8'd0);

        // R5, R3: wait with PLL off in software, wake by internal request.
        sw_pll_on = 0; sw_pll_sel = 0; wait_req = 1; cycle(); wait_req = 0;
        chk("R5 pll honoured", {6'd0, pll_en, pll_sel}, 8'd0);
        int_irq = 1; cycle(); int_irq = 0;
        chk("R3 mask stays clear", {7'd0, irq_mask}, 8'd0);

        // R9: limit zero acts as one; R4: reset out of stop.
        stab_limit = '0; stop_req = 1; cycle(); stop_req = 0;
        ext_irq = 1; cycle(); ext_irq = 0; cycle();
        chk("R9 zero limit", {6'd0, state_o}, 8'd0);
        stop_req = 1; cycle(); stop_req = 0;
        rst_n = 0; cycle(); rst_n = 1;
        chk("R4 reset from stop", {6'd0, state_o, irq_mask}, 8'b001);

        // Random mix against the model.
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] cur;
            cur = state_o;
            rst_n      = ($urandom_range(99) != 0);
            wait_req   = ($urandom_range(9) == 0);
            stop_req   = ($urandom_range(11) == 0);
            mask_set   = ($urandom_range(7) == 0);
            mask_clr   = ($urandom_range(7) == 0);
            ext_irq    = ($urandom_range(15) == 0);
            int_irq    = ($urandom_range(9) == 0);
            brk_irq    = ($urandom_range(19) == 0);
            brk_enable = $urandom_range(1);
            sw_pll_on  = $urandom_range(1);
            sw_pll_sel = $urandom_range(1);
            osc_ready  = ($urandom_range(5) != 0);
            flag_wr    = ($urandom_range(5) == 0);
            flag_wdata = $urandom_range(1);
            osc_keep_cfg = $urandom_range(1);
            if (cur != 2'd3) stab_limit = CNT_W'($urandom_range(6));
            cycle();
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule